// File: doc/BRIEF.md
# PCM Highway Time-Slot Receiver

This block picks one channel out of a time-division PCM highway. A frame sync pulse marks bit position 0 of a frame. Each later PCM clock period moves the bit position on by one. The channel starts at a programmed slot number times eight, plus a programmed bit offset of 0 to 7 periods. That offset absorbs clock skew on the highway. The serial data comes from one of two receive inputs, chosen by a configuration bit.

In companded mode the block takes one 8-bit slot and flags the byte for expansion. In linear mode it takes two adjacent slots as one 16-bit word and flags that expansion is bypassed. The block measures the frame length in clock periods between successive sync pulses. It refuses any window that does not end inside the measured frame. This also covers frames whose length is not a multiple of eight: there, the last full slot can only be used with a small offset.

Top module: `pcm_slot_rx`

## Requirements
- R1: The cycle in which `fsync` is high is bit position 0. The channel window starts at bit position `slot*8 + bit_ofs`.
- R2: One bit is sampled on each rising `clk` edge inside the window, and the first bit is the most significant. `rx_valid` is high for exactly one cycle, in the cycle after the window's last bit.
- R3: When `sel_b` is 0 the data is taken from `rx_a`. When `sel_b` is 1 it is taken from `rx_b`.
- R4: When `linear` is 0 the window is 8 bits. The byte appears on `rx_word[7:0]`, `rx_word[15:8]` is 0 and `need_expand` is 1.
- R5: When `linear` is 1 the window is 16 bits over two adjacent slots. The word appears on `rx_word[15:0]` and `need_expand` is 0.
- R6: The frame length is the count of clock periods from one `fsync` cycle to the next. No `rx_valid` is given until two `fsync` pulses have been seen.
- R7: `cfg_err` is 1 when a frame length has been measured and `slot*8 + bit_ofs + window length` exceeds it. No `rx_valid` is given for such a window. With a 193-period frame, slot 23 is accepted only with `bit_ofs` of 0 or 1.
- R8: During and right after reset, `rx_valid`, `rx_word` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock; rising edge samples |
| rst | input | 1 | Synchronous reset, active high |
| fsync | input | 1 | Frame sync, high for bit position 0 |
| rx_a | input | 1 | Serial receive input A |
| rx_b | input | 1 | Serial receive input B |
| slot | input | SLOT_W | Programmed time slot |
| bit_ofs | input | OFS_W | Window delay in clock periods |
| sel_b | input | 1 | 1 selects input B |
| linear | input | 1 | 1 selects 16-bit two-slot mode |
| rx_word | output | 16 | Captured sample |
| rx_valid | output | 1 | One-cycle strobe for a new sample |
| need_expand | output | 1 | 1 when the sample needs expansion |
| cfg_err | output | 1 | Programmed window exceeds the measured frame |

## Verification
The bench builds the block with `CNT_W = 9`. A frame can then be up to 511 periods long, so a 193-period frame with a one-bit fraction can be tested. The bench also uses the two-slot minimum frame of 16 periods and a 64-period frame. Together these frames put the last usable slot, the offset limit and the linear window straddling the frame end within reach of the bench.

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx #(
  parameter int SLOT_W = 7,
  parameter int OFS_W  = 3,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              rx_a,
  input  logic              rx_b,
  input  logic [SLOT_W-1:0] slot,
  input  logic [OFS_W-1:0]  bit_ofs,
  input  logic              sel_b,
  input  logic              linear,
  output logic [15:0]       rx_word,
  output logic              rx_valid,
  output logic              need_expand,
  output logic              cfg_err
);
  localparam int EW = ((CNT_W > SLOT_W + 4) ? CNT_W : SLOT_W + 4) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pos_q, len_q, pos;
  logic             seen_q;
  logic [15:0]      sh_q;
  logic             din;
  logic [EW-1:0]    start, win_end, last_pos, len_ext;
  logic             fits, at_last;

  assign pos      = fsync ? '0 : pos_q;
  assign din      = sel_b ? rx_b : rx_a;
  assign start    = EW'({slot, 3'b000}) + EW'(bit_ofs);
  assign win_end  = start + (linear ? EW'(16) : EW'(8));
  assign last_pos = win_end - EW'(1);
  assign len_ext  = EW'(len_q);
  assign fits     = win_end <= len_ext;
  assign at_last  = EW'(pos) == last_pos;
  assign cfg_err  = (len_q != '0) && !fits;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= '0;
      len_q       <= '0;
      seen_q      <= 1'b0;
      sh_q        <= '0;
      rx_valid    <= 1'b0;
      rx_word     <= '0;
      need_expand <= 1'b0;
    end else begin
      pos_q <= (pos == CNT_MAX) ? pos : pos + 1'b1;
      if (fsync) begin
        seen_q <= 1'b1;
        if (seen_q) len_q <= pos_q;
      end
      sh_q     <= {sh_q[14:0], din};
      rx_valid <= at_last && fits && (len_q != '0);
      if (at_last && fits && (len_q != '0)) begin
        rx_word     <= linear ? {sh_q[14:0], din} : {8'h00, sh_q[6:0], din};
        need_expand <= !linear;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);                                          // R2
  AST_POS_FROM_SYNC: assert property (@(posedge clk) disable iff (rst)
    $past(fsync) |-> pos_q == CNT_W'(1));                             // R1
  AST_NO_VALID_UNMEASURED: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(len_q) != '0);                                 // R6
  AST_NO_VALID_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !$past(cfg_err));                                    // R7
  AST_EXPAND_FLAG: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> need_expand == !$past(linear));                      // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && need_expand) |-> rx_word[15:8] == 8'h00);            // R4
endmodule

// File: tb/pcm_slot_rx_tb.sv
module pcm_slot_rx_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic fsync = 1'b0, rx_a = 1'b0, rx_b = 1'b0, sel_b = 1'b0, linear = 1'b0;
  logic [6:0] slot = '0;
  logic [2:0] bit_ofs = '0;
  logic [15:0] rx_word;
  logic rx_valid, need_expand, cfg_err;

  int checks = 0, errors = 0;
  int cyc = 0, last_fs = 0, mlen = 0, vld_cnt = 0;
  bit seen = 0;
  int hist = 0;

  always #5 clk = ~clk;

  pcm_slot_rx #(.SLOT_W(7), .OFS_W(3), .CNT_W(9)) u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .rx_a(rx_a), .rx_b(rx_b),
    .slot(slot), .bit_ofs(bit_ofs), .sel_b(sel_b), .linear(linear),
    .rx_word(rx_word), .rx_valid(rx_valid), .need_expand(need_expand),
    .cfg_err(cfg_err));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // Reference step for the edge just passed, then compare outputs.
  task automatic step();
    int p, start, nb, old_len, ew;
    bit ev, din;
    @(negedge clk);
    din = sel_b ? rx_b : rx_a;
    old_len = mlen;
    if (fsync) begin
      if (seen) mlen = cyc - last_fs;   // R6 length between sync pulses
      seen = 1; last_fs = cyc; p = 0;   // R1
    end else p = cyc - last_fs;
    hist = ((hist << 1) | din) & 16'hFFFF;
    start = slot * 8 + bit_ofs;
    nb = linear ? 16 : 8;
    ev = (p == start + nb - 1) && old_len != 0 && (start + nb <= old_len);
    ew = linear ? hist : (hist & 8'hFF);
    cyc++;
    chk("R1 R2 R6 valid", rx_valid, ev);
    if (ev) begin
      vld_cnt++;
      chk(linear ? "R5 R3 word" : "R4 R3 word", rx_word, ew);
      chk(linear ? "R5 flag" : "R4 flag", need_expand, !linear);
    end
    chk("R7 cfg_err", cfg_err, (mlen != 0) && (start + nb > mlen));
    fsync = 1'b0;
    rx_a = 1'($urandom); rx_b = 1'($urandom);
  endtask

  task automatic frames(input int len, input int n);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < len; i++) begin
        if (i == 0) fsync = 1'b1;
        step();
      end
  endtask

  task automatic cfg(input int s, input int o, input bit b, input bit lin);
    slot = 7'(s); bit_ofs = 3'(o); sel_b = b; linear = lin;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R8 valid", rx_valid, 0);
        chk("R8 word", rx_word, 0);
        chk("R8 cfg_err", cfg_err, 0);
        rst = 1'b0;
        rx_a = 1'($urandom); rx_b = 1'($urandom);
        cfg(2, 0, 0, 0); frames(64, 4);
        cfg(5, 5, 1, 0); frames(64, 3);
        cfg(3, 2, 0, 1); frames(64, 3);
        cfg(6, 7, 1, 1); frames(64, 2);      // R7 linear window past frame end
        cfg(23, 1, 0, 0); frames(193, 3);    // R7 last slot usable
        cfg(23, 2, 1, 0); frames(193, 2);    // R7 last slot refused
        cfg(22, 1, 1, 1); frames(193, 2);
        cfg(23, 0, 0, 1); frames(193, 2);
        cfg(1, 0, 0, 0); frames(16, 3);      // two-channel frame
        cfg(2, 0, 1, 0); frames(16, 2);
        chk("R2 valid count seen", vld_cnt > 10, 1);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule